// File: doc/BRIEF.md
# Gated Extended Display Register File

This block is an indexed bank of extended display-controller registers behind an index/data port pair. Software first loads an index and then writes a data byte. Each implemented register keeps the exact byte that was written, so a read returns it unchanged. Some of the stored bits are also sent out as the upper bits of wide timing and address values that other parts of the display controller use:

- the top two bits of the display start address and of the cursor start address;
- bit 10 of the line-compare value;
- a remapped vertical overflow vector and a masked horizontal overflow vector;
- the size of the video memory wrap.

Every index except the identification index 0x33 sits behind an extension enable. While the enable is clear, writes to those indexes are dropped and reads of them return zero. The identification index stays reachable so that probing software can find the extensions before it turns them on. Two single-cycle pulses tell the neighbouring logic when it must act. The first is a resize request, which fires only when the overflow bits that affect the frame geometry really change. The second is a wrap-change pulse, which fires only when the memory configuration register receives a different value.

Top module: `xdr_regfile`

## Requirements
- R1: After reset every stored register reads 0x00, the extension enable is set, all derived outputs reflect zeroed registers (the memory wrap is therefore 32768), and both pulses are low.
- R2: Indexes 0x31, 0x32, 0x33, 0x34, 0x35, 0x36, 0x37 and 0x3F store the full written byte, and reading the selected index returns it unchanged, including bits that drive nothing.
- R3: While the extension enable (loaded by `en_we` with `en_val`) is clear, data writes to every index other than 0x33 have no effect and reads of them return 0x00. Index 0x33 can still be written and read. Stored values survive the disabled period.
- R4: Writes to indexes outside the implemented set change nothing, and reads of them return 0x00.
- R5: `disp_start_hi` equals bits 1:0 of register 0x33, and `cursor_start_hi` equals bits 3:2 of register 0x33.
- R6: `line_cmp_b10` equals bit 4 of register 0x35. `vert_ovf` takes its bits from register 0x35 as follows: bit 0 from bit 1, bit 1 from bit 2, bit 2 from bit 0, bit 3 from bit 3, and bit 4 from bit 4.
- R7: A data write to 0x35 raises `resize_req` for exactly one cycle, registered one cycle after the strobe, only when bits 1:0 of the new `vert_ovf` differ from their old value.
- R8: `horz_ovf` equals register 0x3F masked with 0x15. A data write to 0x3F raises the same one-cycle `resize_req` only when bits 1:0 of the masked value change.
- R9: `mem_wrap` equals 2 to the power (15 + 2·b3 + c) bytes, where b3 is bit 3 and c is bits 1:0 of register 0x37. For c ≥ 1 this is 64 KiB shifted left by 2·b3 + (c − 1).
- R10: A data write to 0x37 raises `wrap_chg` for one cycle, registered one cycle after the strobe, only when the written byte differs from the stored one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Load the extension enable |
| en_val | input | 1 | New extension enable value |
| idx_we | input | 1 | Load the index register |
| idx_in | input | 8 | Index value |
| dat_we | input | 1 | Data write strobe to the selected index |
| dat_in | input | 8 | Data byte |
| rd_data | output | 8 | Read value of the selected index |
| disp_start_hi | output | 2 | Display start address bits 17:16 |
| cursor_start_hi | output | 2 | Cursor start address bits 17:16 |
| line_cmp_b10 | output | 1 | Line compare bit 10 |
| vert_ovf | output | 5 | Remapped vertical overflow vector |
| horz_ovf | output | 8 | Masked horizontal overflow |
| mem_wrap | output | 21 | Video memory wrap size in bytes |
| wrap_chg | output | 1 | One-cycle pulse: memory configuration changed |
| resize_req | output | 1 | One-cycle pulse: frame geometry must be recomputed |

## Verification
A wrong gate decision shows up at the very next read of the selected index: a value that should have been dropped reads back nonzero, or a value that should have been stored reads back as zero. A corrupted remap or mask appears on `vert_ovf` or `horz_ovf` in the cycle after the write. A wrong change comparison shows as a missing or extra pulse on `resize_req` or `wrap_chg` in the cycle right after the strobe. The bench keeps its own model of the stored bytes, so it can predict every pulse. The same model also lets it confirm that a gated write left the earlier contents untouched.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
   localparam int NSLOT = 8;
   localparam int SLW   = $clog2(NSLOT);

   // slot order only fixes which stored byte feeds which derived output
   localparam logic [7:0] SLOT_IDX [NSLOT] = '{8'h31, 8'h32, 8'h33, 8'h34,
                                               8'h35, 8'h36, 8'h37, 8'h3F};
   localparam int SL_ADDR = 2;
   localparam int SL_VOVF = 4;
   localparam int SL_WRAP = 6;
   localparam int SL_HOVF = 7;

   localparam logic [7:0] IDX_OPEN = 8'h33;
   localparam logic [7:0] HMASK    = 8'h15;

   typedef struct packed {
      logic           hit;
      logic [SLW-1:0] slot;
   } slot_t;

   function automatic slot_t decode_idx(input logic [7:0] i);
      slot_t d;
      d = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (SLOT_IDX[s] == i) begin
            d.hit  = 1'b1;
            d.slot = SLW'(s);
         end
      end
      return d;
   endfunction

   function automatic logic [4:0] vremap(input logic [7:0] v);
      return {v[4], v[3], v[0], v[2], v[1]};
   endfunction
endpackage

// File: rtl/xdr_reg_bank.sv
module xdr_reg_bank
   import xdr_pkg::*;
#(
   parameter int DW = 8,
   parameter int NS = NSLOT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_go,
   input  logic [SLW-1:0]         wr_slot,
   input  logic [DW-1:0]          wr_data,
   output logic [NS-1:0][DW-1:0]  regs
);
   for (genvar s = 0; s < NS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[s] <= '0;
         else if (wr_go && (wr_slot == SLW'(s)))
            regs[s] <= wr_data;
      end
   end
endmodule

// File: rtl/xdr_access.sv
module xdr_access
   import xdr_pkg::*;
#(
   parameter int IW = 8,
   parameter int DW = 8,
   parameter int NS = NSLOT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_we,
   input  logic                   en_val,
   input  logic                   idx_we,
   input  logic [IW-1:0]          idx_in,
   input  logic                   dat_we,
   input  logic [NS-1:0][DW-1:0]  regs,
   output logic [IW-1:0]          cur_idx,
   output logic                   ext_en,
   output logic                   wr_go,
   output logic [SLW-1:0]         wr_slot,
   output logic [DW-1:0]          rd_data
);
   slot_t dec;
   logic  open_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_idx <= '0;
         ext_en  <= 1'b1;
      end else begin
         if (idx_we) cur_idx <= idx_in;
         if (en_we)  ext_en  <= en_val;
      end
   end

   always_comb begin
      dec     = decode_idx(cur_idx);
      open_ok = dec.hit && (ext_en || (cur_idx == IDX_OPEN));
      wr_go   = dat_we && open_ok;
      wr_slot = dec.slot;
      rd_data = open_ok ? regs[dec.slot] : '0;
   end
endmodule

// File: rtl/xdr_ovf_map.sv
module xdr_ovf_map
   import xdr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_go,
   input  logic [SLW-1:0]  wr_slot,
   input  logic [DW-1:0]   wr_data,
   input  logic [DW-1:0]   vreg,
   input  logic [DW-1:0]   hreg,
   output logic [4:0]      vert_ovf,
   output logic [DW-1:0]   horz_ovf,
   output logic            line_cmp_b10,
   output logic            resize_req
);
   logic [4:0]    v_new;
   logic [DW-1:0] h_new;
   logic          v_hit, h_hit;

   always_comb begin
      vert_ovf     = vremap(vreg);
      horz_ovf     = hreg & HMASK;
      line_cmp_b10 = vreg[4];
      v_new        = vremap(wr_data);
      h_new        = wr_data & HMASK;
      v_hit = wr_go && (wr_slot == SLW'(SL_VOVF)) && (v_new[1:0] != vert_ovf[1:0]);
      h_hit = wr_go && (wr_slot == SLW'(SL_HOVF)) && (h_new[1:0] != horz_ovf[1:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) resize_req <= 1'b0;
      else        resize_req <= v_hit || h_hit;
   end
endmodule

// File: rtl/xdr_wrap_calc.sv
module xdr_wrap_calc
   import xdr_pkg::*;
#(
   parameter int DW        = 8,
   parameter int BASE_LOG2 = 16,
   parameter int WRAP_W    = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [SLW-1:0]    wr_slot,
   input  logic [DW-1:0]     wr_data,
   input  logic [DW-1:0]     wreg,
   output logic [WRAP_W-1:0] mem_wrap,
   output logic              wrap_chg
);
   localparam int SHW = $clog2(WRAP_W);
   logic [SHW-1:0] sh;

   always_comb begin
      sh = SHW'(BASE_LOG2 - 1) + (wreg[3] ? SHW'(2) : SHW'(0)) + SHW'(wreg[1:0]);
      mem_wrap = WRAP_W'(1) << sh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wrap_chg <= 1'b0;
      else        wrap_chg <= wr_go && (wr_slot == SLW'(SL_WRAP)) && (wr_data != wreg);
   end
endmodule

// File: rtl/xdr_regfile.sv
module xdr_regfile
   import xdr_pkg::*;
#(
   parameter int IW        = 8,
   parameter int DW        = 8,
   parameter int BASE_LOG2 = 16,
   parameter int WRAP_W    = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_we,
   input  logic              en_val,
   input  logic              idx_we,
   input  logic [IW-1:0]     idx_in,
   input  logic              dat_we,
   input  logic [DW-1:0]     dat_in,
   output logic [DW-1:0]     rd_data,
   output logic [1:0]        disp_start_hi,
   output logic [1:0]        cursor_start_hi,
   output logic              line_cmp_b10,
   output logic [4:0]        vert_ovf,
   output logic [DW-1:0]     horz_ovf,
   output logic [WRAP_W-1:0] mem_wrap,
   output logic              wrap_chg,
   output logic              resize_req
);
   if (DW != 8) begin : g_bad_dw
      $error("xdr_regfile: DW must be 8");
   end
   if (IW != 8) begin : g_bad_iw
      $error("xdr_regfile: IW must be 8");
   end
   if (WRAP_W < BASE_LOG2 + 5) begin : g_bad_wrap
      $error("xdr_regfile: WRAP_W too narrow for the largest wrap");
   end

   logic [NSLOT-1:0][DW-1:0] regs;
   logic [IW-1:0]            cur_idx;
   logic                     ext_en;
   logic                     wr_go;
   logic [SLW-1:0]           wr_slot;

   xdr_access #(.IW(IW), .DW(DW), .NS(NSLOT)) acc_i (
      .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_val(en_val),
      .idx_we(idx_we), .idx_in(idx_in), .dat_we(dat_we), .regs(regs),
      .cur_idx(cur_idx), .ext_en(ext_en), .wr_go(wr_go),
      .wr_slot(wr_slot), .rd_data(rd_data));

   xdr_reg_bank #(.DW(DW), .NS(NSLOT)) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_slot(wr_slot),
      .wr_data(dat_in), .regs(regs));

   xdr_ovf_map #(.DW(DW)) ovf_i (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_slot(wr_slot),
      .wr_data(dat_in), .vreg(regs[SL_VOVF]), .hreg(regs[SL_HOVF]),
      .vert_ovf(vert_ovf), .horz_ovf(horz_ovf),
      .line_cmp_b10(line_cmp_b10), .resize_req(resize_req));

   xdr_wrap_calc #(.DW(DW), .BASE_LOG2(BASE_LOG2), .WRAP_W(WRAP_W)) wrap_i (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_slot(wr_slot),
      .wr_data(dat_in), .wreg(regs[SL_WRAP]),
      .mem_wrap(mem_wrap), .wrap_chg(wrap_chg));

   always_comb begin
      disp_start_hi   = regs[SL_ADDR][1:0];
      cursor_start_hi = regs[SL_ADDR][3:2];
   end
endmodule

// File: rtl/xdr_regfile_chk.sv
module xdr_regfile_chk
   import xdr_pkg::*;
#(
   parameter int WRAP_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dat_we,
   input logic [7:0]        cur_idx,
   input logic              ext_en,
   input logic [7:0]        rd_data,
   input logic [1:0]        disp_start_hi,
   input logic [1:0]        cursor_start_hi,
   input logic [7:0]        horz_ovf,
   input logic [WRAP_W-1:0] mem_wrap,
   input logic              wrap_chg,
   input logic              resize_req
);
   slot_t d;
   always_comb d = decode_idx(cur_idx);

   // R3
   gate_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_en && cur_idx != IDX_OPEN) |-> rd_data == 8'h00);

   // R4
   unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !d.hit |-> rd_data == 8'h00);

   // R5
   addr_hi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({cursor_start_hi, disp_start_hi}) |-> $past(dat_we && cur_idx == IDX_OPEN));

   // R7
   resize_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resize_req |-> $past(dat_we && (cur_idx == 8'h35 || cur_idx == 8'h3F)));

   // R8
   horz_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (horz_ovf & 8'hEA) == 8'h00);

   // R9
   wrap_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mem_wrap) == 1);

   // R10
   wrap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_chg |-> $past(dat_we && cur_idx == 8'h37));
endmodule

bind xdr_regfile xdr_regfile_chk #(.WRAP_W(WRAP_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .cur_idx(cur_idx),
   .ext_en(ext_en), .rd_data(rd_data), .disp_start_hi(disp_start_hi),
   .cursor_start_hi(cursor_start_hi), .horz_ovf(horz_ovf),
   .mem_wrap(mem_wrap), .wrap_chg(wrap_chg), .resize_req(resize_req));

// File: tb/xdr_regfile_tb.sv
module xdr_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_we = 1'b0, en_val = 1'b0;
   logic        idx_we = 1'b0, dat_we = 1'b0;
   logic [7:0]  idx_in = '0, dat_in = '0;
   logic [7:0]  rd_data;
   logic [1:0]  disp_start_hi, cursor_start_hi;
   logic        line_cmp_b10;
   logic [4:0]  vert_ovf;
   logic [7:0]  horz_ovf;
   logic [20:0] mem_wrap;
   logic        wrap_chg, resize_req;

   int errors = 0;
   int checks = 0;
   logic [7:0] mdl [256];
   logic       m_en = 1'b1;

   always #5 clk = ~clk;

   xdr_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_val(en_val),
      .idx_we(idx_we), .idx_in(idx_in), .dat_we(dat_we), .dat_in(dat_in),
      .rd_data(rd_data), .disp_start_hi(disp_start_hi),
      .cursor_start_hi(cursor_start_hi), .line_cmp_b10(line_cmp_b10),
      .vert_ovf(vert_ovf), .horz_ovf(horz_ovf), .mem_wrap(mem_wrap),
      .wrap_chg(wrap_chg), .resize_req(resize_req));

   function automatic bit impl(input logic [7:0] i);
      return (i >= 8'h31 && i <= 8'h37) || i == 8'h3F;
   endfunction

   function automatic logic [4:0] vmap(input logic [7:0] v);
      logic [4:0] r;
      r[0] = v[1]; r[1] = v[2]; r[2] = v[0]; r[3] = v[3]; r[4] = v[4];
      return r;
   endfunction

   function automatic logic [20:0] wrap_of(input logic [7:0] v);
      return 21'd1 << (15 + (v[3] ? 2 : 0) + int'(v[1:0]));
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_en(input logic v);
      @(negedge clk); en_we = 1'b1; en_val = v;
      @(negedge clk); en_we = 1'b0;
      m_en = v;
   endtask

   task automatic rd_chk(input logic [7:0] i, input logic [7:0] exp, input string tag);
      @(negedge clk); idx_we = 1'b1; idx_in = i;
      @(negedge clk); idx_we = 1'b0;
      chk(rd_data == exp, tag, {24'h0, rd_data}, {24'h0, exp});
   endtask

   task automatic wr(input logic [7:0] i, input logic [7:0] v);
      bit ok, exp_rs, exp_wc;
      logic [7:0] old;
      ok     = impl(i) && (m_en || i == 8'h33);
      old    = mdl[i];
      exp_rs = ok && ((i == 8'h35 && vmap(v)[1:0] != vmap(old)[1:0]) ||
                      (i == 8'h3F && v[0] != old[0]));
      exp_wc = ok && i == 8'h37 && v != old;
      @(negedge clk); idx_we = 1'b1; idx_in = i;
      @(negedge clk); idx_we = 1'b0; dat_we = 1'b1; dat_in = v;
      @(negedge clk); dat_we = 1'b0;
      chk(resize_req == exp_rs, (i == 8'h3F) ? "R8 resize" : "R7 resize",
          {31'h0, resize_req}, {31'h0, exp_rs});
      chk(wrap_chg == exp_wc, "R10 wrap_chg", {31'h0, wrap_chg}, {31'h0, exp_wc});
      @(negedge clk);
      chk(!resize_req && !wrap_chg, "R7 pulse width", {30'h0, resize_req, wrap_chg}, 32'h0);
      if (ok) mdl[i] = v;
   endtask

   task automatic t_reset;
      // R1
      chk(!resize_req && !wrap_chg, "R1 pulses", {30'h0, resize_req, wrap_chg}, 32'h0);
      chk(vert_ovf == 0 && horz_ovf == 0 && disp_start_hi == 0 && cursor_start_hi == 0
          && !line_cmp_b10, "R1 derived", {19'h0, vert_ovf, horz_ovf}, 32'h0);
      chk(mem_wrap == 21'd32768, "R1 wrap", {11'h0, mem_wrap}, 32'd32768);
      rd_chk(8'h31, 8'h00, "R1 reg31");
      rd_chk(8'h3F, 8'h00, "R1 reg3F");
      rd_chk(8'h36, 8'h00, "R1 reg36 (enable set)");
   endtask

   task automatic t_readback;
      wr(8'h31, 8'hA5); wr(8'h32, 8'h5A); wr(8'h34, 8'hFF); wr(8'h36, 8'h81);
      rd_chk(8'h31, 8'hA5, "R2 reg31");
      rd_chk(8'h32, 8'h5A, "R2 reg32");
      rd_chk(8'h34, 8'hFF, "R2 reg34");
      rd_chk(8'h36, 8'h81, "R2 reg36");
   endtask

   task automatic t_addr;
      wr(8'h33, 8'hFB);
      chk(disp_start_hi == 2'd3 && cursor_start_hi == 2'd2, "R5 addr hi",
          {28'h0, cursor_start_hi, disp_start_hi}, 32'hB);
      rd_chk(8'h33, 8'hFB, "R2 reg33");
   endtask

   task automatic t_vert;
      logic [7:0] seq [4] = '{8'h13, 8'h19, 8'h1D, 8'h0C};
      foreach (seq[k]) begin
         wr(8'h35, seq[k]);
         chk(vert_ovf == vmap(seq[k]), "R6 vert_ovf", {27'h0, vert_ovf}, {27'h0, vmap(seq[k])});
         chk(line_cmp_b10 == seq[k][4], "R6 line cmp", {31'h0, line_cmp_b10}, {31'h0, seq[k][4]});
      end
      rd_chk(8'h35, 8'h0C, "R2 reg35");
   endtask

   task automatic t_horz;
      logic [7:0] seq [3] = '{8'hFF, 8'hFE, 8'hFA};
      foreach (seq[k]) begin
         wr(8'h3F, seq[k]);
         chk(horz_ovf == (seq[k] & 8'h15), "R8 horz_ovf", {24'h0, horz_ovf},
             {24'h0, seq[k] & 8'h15});
      end
      rd_chk(8'h3F, 8'hFA, "R2 reg3F");
   endtask

   task automatic t_wrap;
      logic [7:0] seq [5] = '{8'h0C, 8'h03, 8'h0B, 8'h01, 8'h01};
      foreach (seq[k]) begin
         wr(8'h37, seq[k]);
         chk(mem_wrap == wrap_of(seq[k]), "R9 mem_wrap", {11'h0, mem_wrap},
             {11'h0, wrap_of(seq[k])});
      end
      rd_chk(8'h37, 8'h01, "R2 reg37");
   endtask

   task automatic t_unmapped;
      wr(8'h30, 8'h77); wr(8'h38, 8'h66); wr(8'h00, 8'h55); wr(8'hFF, 8'h44);
      rd_chk(8'h30, 8'h00, "R4 idx30");
      rd_chk(8'h38, 8'h00, "R4 idx38");
      rd_chk(8'hFF, 8'h00, "R4 idxFF");
      rd_chk(8'h31, 8'hA5, "R4 neighbour intact");
      chk(vert_ovf == vmap(8'h0C) && mem_wrap == wrap_of(8'h01), "R4 derived intact",
          {11'h0, mem_wrap}, {11'h0, wrap_of(8'h01)});
   endtask

   task automatic t_gate;
      set_en(1'b0);
      wr(8'h31, 8'h11);
      rd_chk(8'h31, 8'h00, "R3 gated read");
      wr(8'h35, 8'h02);
      chk(vert_ovf == vmap(8'h0C), "R3 gated vert", {27'h0, vert_ovf}, {27'h0, vmap(8'h0C)});
      wr(8'h37, 8'h0F);
      chk(mem_wrap == wrap_of(8'h01), "R3 gated wrap", {11'h0, mem_wrap},
          {11'h0, wrap_of(8'h01)});
      wr(8'h33, 8'h06);
      chk(disp_start_hi == 2'd2 && cursor_start_hi == 2'd1, "R3 open index",
          {28'h0, cursor_start_hi, disp_start_hi}, 32'h6);
      rd_chk(8'h33, 8'h06, "R3 open read");
      set_en(1'b1);
      rd_chk(8'h31, 8'hA5, "R3 kept value");
      rd_chk(8'h35, 8'h0C, "R3 kept vert");
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_addr();
      t_vert();
      t_horz();
      t_wrap();
      t_unmapped();
      t_gate();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule